// File: doc/BRIEF.md
# Privileged Trap Entry Sequencer

This block steers a simple 64-bit CPU into and out of its privileged firmware mode. Whenever a fault or interrupt is reported, it redirects fetch to a vector above a fixed privileged base address. It also records the address at which normal execution should resume, and it brings in a private copy of a few integer registers so that firmware can use them without saving the originals first. When firmware asks to return, the block redirects fetch back to the saved address. The private copies are put away again only when that address leaves privileged mode.

The privileged-mode indication is bit 0 of a program counter. Every vector has that bit set. The current PC of the instruction being retired arrives on `cur_pc`, so the caller's mode is `cur_pc[0]`. The register bank lives inside the block and has one write port and one registered read port. Which physical copy an index reaches depends on the current bank select.

Top module: `ptes_top`

## Requirements
- R1: After synchronous reset, `shadow_sel_o` is 1, `pc_o` is BASE+0x001, `npc_o` is `pc_o`+4, `exc_addr_o` is 0, and registers 0 and 16 read back `cpu_id`. All other registers in both copies read back 0.
- R2: An event with `ev_valid`=1 and a known `ev_code` sets `pc_o` to BASE plus the code's offset on the next edge, sets `npc_o` to `pc_o`+4, and pulses `redir_o` for one cycle. The known codes and their offsets are 0 (machine check) 0x401, 1 (misalignment) 0x301, 2 (interrupt) 0x101, 3 (firmware call) 0x2001, 4 (arithmetic) 0x501 and 5 (illegal operation) 0x481.
- R3: On entry, `exc_addr_o` takes `cur_pc`. For codes 3 and 4 it takes `cur_pc`+4 instead, so the trapping instruction is skipped.
- R4: An interrupt (code 2) taken while `cur_pc[0]`=1 still vectors, but it leaves `exc_addr_o` unchanged.
- R5: Every known event sets `shadow_sel_o` to 1 and never raises `bank_err_o`.
- R6: A return request (`ret_req`) while `cur_pc[0]`=1 loads `pc_o` with `exc_addr_o` and `npc_o` with that address +4, and pulses `redir_o`. `shadow_sel_o` falls to 0 only when bit 0 of that address is 0.
- R7: A return request while `cur_pc[0]`=0 pulses `unimpl_o` for one cycle. It leaves `pc_o`, `npc_o`, `exc_addr_o` and `shadow_sel_o` unchanged and does not pulse `redir_o`.
- R8: A bank request (`swap_req`) to the state `shadow_sel_o` already has pulses `bank_err_o` and changes nothing. A request to the other state moves `shadow_sel_o` to `swap_to` without an error.
- R9: Registers 8 to 14 and 25 have separate normal and private copies, selected by `shadow_sel_o`. All other registers are one copy shared by both states.
- R10: Register 31 reads 0 and ignores writes in both states.
- R11: Events with codes 6 and 7 are ignored: no redirect, and `pc_o`, `exc_addr_o` and `shadow_sel_o` are unchanged.
- R12: `rd_data` shows the register at `rd_addr` one clock after the address is applied. A write in the same cycle is not yet visible.
- R13: When several requests arrive in one cycle, a known event wins over a return, and a return wins over a bank request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_id | input | XLEN | Identifier loaded into registers 0 and 16 at reset |
| ev_valid | input | 1 | One-cycle strobe for a fault or interrupt |
| ev_code | input | 3 | Encoded event kind |
| cur_pc | input | XLEN | PC of the instruction being retired; bit 0 is the mode |
| ret_req | input | 1 | Return-from-firmware request |
| swap_req | input | 1 | Explicit bank change request |
| swap_to | input | 1 | Requested bank state (1 = private copies) |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register write index |
| wr_data | input | XLEN | Register write data |
| rd_addr | input | 5 | Register read index |
| rd_data | output | XLEN | Registered read data |
| pc_o | output | XLEN | Redirected PC |
| npc_o | output | XLEN | Following PC |
| exc_addr_o | output | XLEN | Saved resume address |
| shadow_sel_o | output | 1 | Private register copies selected |
| redir_o | output | 1 | One-cycle pulse when the PC was redirected |
| bank_err_o | output | 1 | One-cycle pulse for a redundant bank request |
| unimpl_o | output | 1 | One-cycle pulse for a return outside privileged mode |

## Verification
The bench aims at the corners where a plausible design slips. An interrupt taken from firmware must not overwrite the resume address; a design that saved it anyway would return to the firmware instruction. A firmware call or arithmetic trap must save PC+4; without the skip the call would execute forever. A return to an address with bit 0 set must keep the private copies; dropping them would corrupt firmware state. A redundant bank request must flag an error; a design that merely toggled the select would swap registers silently. Register reads around bank changes, register 31, and the ignored codes 6 and 7 are checked every cycle against a bench model.

// File: rtl/ptes_pkg.sv
`timescale 1ns/1ps
package ptes_pkg;
  localparam int NREG    = 32;
  localparam int NSHADOW = 8;
  localparam int RW      = $clog2(NREG);
  localparam int SW      = $clog2(NSHADOW);
  localparam int VW      = 16;

  localparam logic [2:0] EV_MCHK  = 3'd0;
  localparam logic [2:0] EV_ALIGN = 3'd1;
  localparam logic [2:0] EV_INTR  = 3'd2;
  localparam logic [2:0] EV_CALL  = 3'd3;
  localparam logic [2:0] EV_ARITH = 3'd4;
  localparam logic [2:0] EV_ILL   = 3'd5;

  localparam logic [VW-1:0] RESET_VEC = 16'h0001;
  localparam logic [RW-1:0] ZERO_REG  = 5'd31;

  // Indices with a private copy: 8..14 and 25
  function automatic logic has_private(input logic [RW-1:0] idx);
    return ((idx >= 5'd8) && (idx <= 5'd14)) || (idx == 5'd25);
  endfunction

  function automatic logic [SW-1:0] private_slot(input logic [RW-1:0] idx);
    logic [RW-1:0] d;
    d = idx - 5'd8;
    return (idx == 5'd25) ? 3'd7 : d[SW-1:0];
  endfunction
endpackage

// File: rtl/ptes_vector.sv
`timescale 1ns/1ps
module ptes_vector
  import ptes_pkg::*;
(
  input  logic [2:0]    code,
  output logic          known,
  output logic [VW-1:0] offset,
  output logic          skip
);
  always_comb begin
    known  = 1'b1;
    skip   = 1'b0;
    offset = '0;
    case (code)
      EV_MCHK:  offset = 16'h0401;
      EV_ALIGN: offset = 16'h0301;
      EV_INTR:  offset = 16'h0101;
      EV_CALL:  begin offset = 16'h2001; skip = 1'b1; end
      EV_ARITH: begin offset = 16'h0501; skip = 1'b1; end
      EV_ILL:   offset = 16'h0481;
      default:  known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptes_regbank.sv
`timescale 1ns/1ps
module ptes_regbank
  import ptes_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] cpu_id,
  input  logic            sel,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [RW-1:0]   rd_addr,
  output logic [XLEN-1:0] rd_data
);
  logic [XLEN-1:0] base_q [NREG];
  logic [XLEN-1:0] priv_q [NSHADOW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++)
        base_q[i] <= (i == 0 || i == 16) ? cpu_id : '0;
      for (int j = 0; j < NSHADOW; j++)
        priv_q[j] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && wr_addr != ZERO_REG) begin
        if (sel && has_private(wr_addr))
          priv_q[private_slot(wr_addr)] <= wr_data;
        else
          base_q[wr_addr] <= wr_data;
      end
      if (rd_addr == ZERO_REG)
        rd_data <= '0;
      else if (sel && has_private(rd_addr))
        rd_data <= priv_q[private_slot(rd_addr)];
      else
        rd_data <= base_q[rd_addr];
    end
  end
endmodule

// File: rtl/ptes_ctrl.sv
`timescale 1ns/1ps
module ptes_ctrl
  import ptes_pkg::*;
#(
  parameter int          XLEN = 64,
  parameter logic [63:0] BASE = 64'h0000_0000_0020_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_valid,
  input  logic [2:0]      ev_code,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            ret_req,
  input  logic            swap_req,
  input  logic            swap_to,
  input  logic            known,
  input  logic [VW-1:0]   offset,
  input  logic            skip,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] npc_q,
  output logic [XLEN-1:0] exc_q,
  output logic            sel_q,
  output logic            redir_q,
  output logic            err_q,
  output logic            unimpl_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  localparam logic [XLEN-1:0] BASE_X = BASE[XLEN-1:0];

  logic [XLEN-1:0] target;
  logic [XLEN-1:0] resume;
  logic            keep_exc;
  logic            in_priv;

  always_comb begin
    target   = BASE_X + XLEN'(offset);
    resume   = cur_pc + (skip ? STEP : '0);
    in_priv  = cur_pc[0];
    keep_exc = (ev_code == EV_INTR) && in_priv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= BASE_X + XLEN'(RESET_VEC);
      npc_q    <= BASE_X + XLEN'(RESET_VEC) + STEP;
      exc_q    <= '0;
      sel_q    <= 1'b1;
      redir_q  <= 1'b0;
      err_q    <= 1'b0;
      unimpl_q <= 1'b0;
    end else begin
      redir_q  <= 1'b0;
      err_q    <= 1'b0;
      unimpl_q <= 1'b0;
      if (ev_valid && known) begin
        pc_q    <= target;
        npc_q   <= target + STEP;
        redir_q <= 1'b1;
        sel_q   <= 1'b1;
        if (!keep_exc)
          exc_q <= resume;
      end else if (ret_req) begin
        if (in_priv) begin
          pc_q    <= exc_q;
          npc_q   <= exc_q + STEP;
          redir_q <= 1'b1;
          if (!exc_q[0])
            sel_q <= 1'b0;
        end else begin
          unimpl_q <= 1'b1;
        end
      end else if (swap_req) begin
        if (swap_to == sel_q)
          err_q <= 1'b1;
        else
          sel_q <= swap_to;
      end
    end
  end
endmodule

// File: rtl/ptes_top.sv
`timescale 1ns/1ps
module ptes_top
  import ptes_pkg::*;
#(
  parameter int          XLEN = 64,
  parameter logic [63:0] BASE = 64'h0000_0000_0020_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] cpu_id,
  input  logic            ev_valid,
  input  logic [2:0]      ev_code,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            ret_req,
  input  logic            swap_req,
  input  logic            swap_to,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [4:0]      rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] exc_addr_o,
  output logic            shadow_sel_o,
  output logic            redir_o,
  output logic            bank_err_o,
  output logic            unimpl_o
);
  logic          known;
  logic [VW-1:0] offset;
  logic          skip;

  ptes_vector u_vec (
    .code   (ev_code),
    .known  (known),
    .offset (offset),
    .skip   (skip)
  );

  ptes_ctrl #(.XLEN(XLEN), .BASE(BASE)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .ev_code  (ev_code),
    .cur_pc   (cur_pc),
    .ret_req  (ret_req),
    .swap_req (swap_req),
    .swap_to  (swap_to),
    .known    (known),
    .offset   (offset),
    .skip     (skip),
    .pc_q     (pc_o),
    .npc_q    (npc_o),
    .exc_q    (exc_addr_o),
    .sel_q    (shadow_sel_o),
    .redir_q  (redir_o),
    .err_q    (bank_err_o),
    .unimpl_q (unimpl_o)
  );

  ptes_regbank #(.XLEN(XLEN)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .cpu_id  (cpu_id),
    .sel     (shadow_sel_o),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/ptes_checker.sv
`timescale 1ns/1ps
module ptes_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            ev_valid,
  input logic [2:0]      ev_code,
  input logic [XLEN-1:0] cur_pc,
  input logic            ret_req,
  input logic            swap_req,
  input logic            swap_to,
  input logic [4:0]      rd_addr,
  input logic [XLEN-1:0] rd_data,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] npc_o,
  input logic [XLEN-1:0] exc_addr_o,
  input logic            shadow_sel_o,
  input logic            redir_o,
  input logic            bank_err_o,
  input logic            unimpl_o
);
  // R2: the following PC is always one instruction past a redirect
  a_r2_npc_step: assert property (@(posedge clk) disable iff (rst)
    redir_o |-> npc_o == pc_o + XLEN'(4));

  // R3: machine check saves the faulting PC unchanged
  a_r3_exc_capture: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_code == 3'd0) |=> exc_addr_o == $past(cur_pc));

  // R5: any known event selects the private copies without error
  a_r5_entry_select: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_code <= 3'd5) |=> (shadow_sel_o && !bank_err_o));

  // R6: an accepted return jumps to the saved address
  a_r6_return_pc: assert property (@(posedge clk) disable iff (rst)
    (ret_req && cur_pc[0] && !ev_valid) |=> (redir_o && pc_o == $past(exc_addr_o)));

  // R7: a return from normal mode is refused
  a_r7_reject: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !cur_pc[0] && !ev_valid) |=> (unimpl_o && !redir_o && $stable(pc_o)));

  // R8: a redundant bank request flags and keeps the select
  a_r8_redundant: assert property (@(posedge clk) disable iff (rst)
    (swap_req && !ev_valid && !ret_req && swap_to == shadow_sel_o)
      |=> (bank_err_o && $stable(shadow_sel_o)));

  // R10: register 31 always reads zero
  a_r10_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == 5'd31) |=> rd_data == '0);

  // R11: unknown codes leave state alone
  a_r11_ignore: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_code > 3'd5 && !ret_req && !swap_req)
      |=> (!redir_o && $stable(exc_addr_o) && $stable(shadow_sel_o)));
endmodule

bind ptes_top ptes_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_ptes_top.sv
`timescale 1ns/1ps
module tb_ptes_top;
  localparam logic [63:0] BASE = 64'h0000_0000_0020_0000;
  localparam logic [63:0] ID   = 64'h0000_0000_0000_0003;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] cpu_id;
  logic        ev_valid;
  logic [2:0]  ev_code;
  logic [63:0] cur_pc;
  logic        ret_req, swap_req, swap_to, wr_en;
  logic [4:0]  wr_addr, rd_addr;
  logic [63:0] wr_data;
  logic [63:0] rd_data, pc_o, npc_o, exc_addr_o;
  logic        shadow_sel_o, redir_o, bank_err_o, unimpl_o;

  ptes_top #(.XLEN(64), .BASE(BASE)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [63:0] m_base [32];
  logic [63:0] m_priv [8];
  logic [63:0] m_pc, m_npc, m_exc;
  logic        m_sel;

  function automatic logic priv_reg(input logic [4:0] a);
    return (a >= 5'd8 && a <= 5'd14) || a == 5'd25;
  endfunction
  function automatic int slot_of(input logic [4:0] a);
    return (a == 5'd25) ? 7 : int'(a) - 8;
  endfunction
  function automatic logic [63:0] vec_of(input logic [2:0] c);
    case (c)
      3'd0: return 64'h401;
      3'd1: return 64'h301;
      3'd2: return 64'h101;
      3'd3: return 64'h2001;
      3'd4: return 64'h501;
      default: return 64'h481;
    endcase
  endfunction
  function automatic logic [63:0] model_read(input logic [4:0] a);
    if (a == 5'd31) return 64'd0;
    if (m_sel && priv_reg(a)) return m_priv[slot_of(a)];
    return m_base[a];
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ev_valid = 0; ret_req = 0; swap_req = 0; wr_en = 0;
  endtask

  // One clock: inputs are already set (at a falling edge); predict, clock, compare.
  task automatic step(input string tag);
    logic [63:0] e_rd;
    logic e_redir, e_err, e_un;
    string rtag;
    e_rd = model_read(rd_addr);
    rtag = (rd_addr == 5'd31) ? "R10" : (priv_reg(rd_addr) ? "R12 R9" : "R12");
    e_redir = 0; e_err = 0; e_un = 0;
    if (wr_en && wr_addr != 5'd31) begin
      if (m_sel && priv_reg(wr_addr)) m_priv[slot_of(wr_addr)] = wr_data;
      else m_base[wr_addr] = wr_data;
    end
    if (ev_valid && ev_code <= 3'd5) begin
      m_pc = BASE + vec_of(ev_code);
      m_npc = m_pc + 64'd4;
      e_redir = 1;
      m_sel = 1;
      if (!(ev_code == 3'd2 && cur_pc[0]))
        m_exc = cur_pc + ((ev_code == 3'd3 || ev_code == 3'd4) ? 64'd4 : 64'd0);
    end else if (ret_req) begin
      if (cur_pc[0]) begin
        m_pc = m_exc; m_npc = m_exc + 64'd4; e_redir = 1;
        if (!m_exc[0]) m_sel = 0;
      end else e_un = 1;
    end else if (swap_req) begin
      if (swap_to == m_sel) e_err = 1;
      else m_sel = swap_to;
    end
    @(posedge clk);
    @(negedge clk);
    check(pc_o == m_pc, tag, "pc", pc_o, m_pc);
    check(npc_o == m_npc, tag, "npc", npc_o, m_npc);
    check(exc_addr_o == m_exc, tag, "exc_addr", exc_addr_o, m_exc);
    check(shadow_sel_o == m_sel, tag, "shadow_sel", 64'(shadow_sel_o), 64'(m_sel));
    check(redir_o == e_redir, tag, "redir", 64'(redir_o), 64'(e_redir));
    check(bank_err_o == e_err, tag, "bank_err", 64'(bank_err_o), 64'(e_err));
    check(unimpl_o == e_un, tag, "unimpl", 64'(unimpl_o), 64'(e_un));
    check(rd_data == e_rd, rtag, "rd_data", rd_data, e_rd);
    idle();
  endtask

  task automatic do_event(input logic [2:0] c, input logic [63:0] p);
    ev_valid = 1; ev_code = c; cur_pc = p;
    if (c > 3'd5) step("R11");
    else if (c == 3'd2 && p[0]) step("R4");
    else step("R2 R3 R5");
  endtask

  task automatic do_return(input logic [63:0] p);
    ret_req = 1; cur_pc = p;
    step(p[0] ? "R6" : "R7");
  endtask

  task automatic do_swap(input logic to);
    swap_req = 1; swap_to = to;
    step("R8");
  endtask

  task automatic do_write(input logic [4:0] a, input logic [63:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(a == 5'd31 ? "R10" : "R9");
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    cpu_id = ID; idle(); ev_code = 0; cur_pc = 0; swap_to = 0;
    wr_addr = 0; wr_data = 0; rd_addr = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 32; i++) m_base[i] = (i == 0 || i == 16) ? ID : 64'd0;
    for (int i = 0; i < 8; i++) m_priv[i] = 64'd0;
    m_pc = BASE + 64'h1; m_npc = BASE + 64'h5; m_exc = 0; m_sel = 1;
    // R1 reset state
    check(pc_o == BASE + 64'h1, "R1", "reset pc", pc_o, BASE + 64'h1);
    check(npc_o == BASE + 64'h5, "R1", "reset npc", npc_o, BASE + 64'h5);
    check(exc_addr_o == 0, "R1", "reset exc", exc_addr_o, 64'd0);
    check(shadow_sel_o == 1, "R1", "reset sel", 64'(shadow_sel_o), 64'd1);
    rd_addr = 5'd0;  step("R1");
    rd_addr = 5'd16; step("R1");
    check(rd_data == ID, "R1", "r16 id", rd_data, ID);

    // directed corners
    do_write(5'd9, 64'hAAAA);           // R9 private copy
    do_write(5'd3, 64'h3333);           // shared
    do_write(5'd31, 64'hDEAD);          // R10
    rd_addr = 5'd31; step("R10");
    do_swap(1'b1);                      // R8 redundant
    do_swap(1'b0);                      // R8 change
    rd_addr = 5'd9; step("R9");          // normal copy reads 0
    do_write(5'd9, 64'hBBBB);
    do_swap(1'b0);                      // R8 redundant while normal
    do_event(3'd3, 64'h1000);           // R3 skip
    do_event(3'd2, 64'h2001);           // R4 interrupt in firmware
    do_event(3'd6, 64'h3000);           // R11
    do_event(3'd7, 64'h3000);           // R11
    do_return(64'h4000);                // R7 refused
    rd_addr = 5'd9; step("R9");
    do_event(3'd1, 64'h5001);           // saved address odd
    do_return(64'h0011);                // R6 stays in firmware
    do_event(3'd4, 64'h6000);           // R3 arithmetic skip
    do_return(64'h0101);                // R6 leaves firmware
    // R13: event beats return and bank request
    ev_valid = 1; ev_code = 3'd0; ret_req = 1; swap_req = 1; swap_to = 0;
    cur_pc = 64'h7001; step("R13");
    ret_req = 1; swap_req = 1; swap_to = 1'b1; cur_pc = 64'h7001; step("R13");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [63:0] p;
      op = int'($urandom_range(0, 5));
      p = {$urandom(), $urandom()};
      rd_addr = 5'($urandom_range(0, 31));
      case (op)
        0: do_event(3'($urandom_range(0, 7)), p);
        1: do_return(p);
        2: do_swap(1'($urandom_range(0, 1)));
        3, 4: begin
          logic [4:0] a;
          a = ($urandom_range(0, 3) == 0) ? 5'd25 : 5'($urandom_range(0, 31));
          do_write(a, {$urandom(), $urandom()});
        end
        default: step("R12");
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule